// File: doc/BRIEF.md
# Modem Control and Status Unit

This unit keeps the modem control byte and the modem status byte of a 16550-style serial port. It brings four asynchronous handshake inputs (clear-to-send, data-set-ready, carrier detect and ring indicator) into the clock domain through flop chains. It records every change of those inputs in sticky change flags, and reports to the interrupt logic when any flag is pending. The ring indicator flag is special: it is raised only when the ring line falls, so a rising ring line leaves it clear.

The host writes the control byte through a write strobe and reads the status byte through a read strobe. A status read outside loopback returns the current byte, and the change flags are cleared at the end of the read cycle. If a new change arrives in that same cycle, its flag survives. When the loopback bit of the control byte is set, a status read returns the control outputs rearranged as status inputs. In that mode the stored status and flags are frozen, and reads do not clear them. When loopback ends, the stored status catches up with the pins and flags any difference.

Top module: `modem_status_ctl`

## Requirements
- R1: After reset, `ctl_q` is 0x08 (only the OUT2 bit set), a status read returns 0xB0, and `delta_any` is low.
- R2: A write stores only `ctl_wdata[4:0]` into `ctl_q`. The fields are bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2 and bit 4 loopback. The upper three data bits are discarded.
- R3: Outside loopback, the upper nibble of a status read shows the pins: bit 7 carrier detect, bit 6 ring, bit 5 data-set-ready, bit 4 clear-to-send. A pin change is visible from the third rising clock edge after it.
- R4: Outside loopback, a change in either direction of carrier detect, data-set-ready or clear-to-send sets status bit 3, 1 or 0 respectively. The bit stays set until it is cleared.
- R5: Status bit 2 is set when the ring pin goes from 1 to 0. A 0-to-1 ring transition does not set it.
- R6: A status read outside loopback returns the current byte and clears bits 3:0 at the clock edge that ends the read cycle.
- R7: If a change is detected in the same cycle as a clearing read, its flag is set after the read. The read itself returns the flags as they were before that change.
- R8: With `ctl_q[4]` set, a status read returns OUT2 in bit 7, OUT1 in bit 6, DTR in bit 5 and RTS in bit 4, with bits 3:0 reading 0.
- R9: While `ctl_q[4]` is set, the stored status and flags do not change, reads do not clear them, and pin changes are ignored. After loopback ends, each difference between the pins and the held status raises its flag.
- R10: `delta_any` is high exactly when at least one of the four stored change flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_q | output | 5 | Stored control bits |
| sts_rd | input | 1 | Status read strobe, one cycle per read |
| sts_rdata | output | 8 | Status byte returned for the current read |
| pin_cts | input | 1 | Clear-to-send pin, asynchronous |
| pin_dsr | input | 1 | Data-set-ready pin, asynchronous |
| pin_dcd | input | 1 | Carrier-detect pin, asynchronous |
| pin_ri | input | 1 | Ring-indicator pin, asynchronous |
| delta_any | output | 1 | At least one change flag is pending |

## Verification
Flag clearing by a host read and flag setting by a synchronised pin change can land on the same clock edge. The bench provokes this by first leaving one flag pending. It then toggles a second pin and raises the read strobe in the exact cycle in which the synchronised value first differs from the stored status, which is the second falling edge after the pin change. The result passes when that read returns the old flag only, and the next read shows the new flag alone, with the earlier flag cleared.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  localparam int NLINES = 4;
  localparam int CTL_W  = 5;
  localparam int REG_W  = 8;

  // Order of members is the bit order of the status nibble (MSB first).
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;

  // Order of members is the bit order of the control field (MSB first).
  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mdm_ctl_t;

  localparam mdm_lines_t LINES_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
  localparam mdm_ctl_t   CTL_RST   = '{loop: 1'b0, out2: 1'b1, out1: 1'b0,
                                       rts: 1'b0, dtr: 1'b0};

  // Loopback wiring of control outputs onto status inputs.
  function automatic mdm_lines_t loop_map(input mdm_ctl_t c);
    mdm_lines_t l;
    l.dcd = c.out2;
    l.ri  = c.out1;
    l.dsr = c.dtr;
    l.cts = c.rts;
    return l;
  endfunction

endpackage

// File: rtl/mdm_rst_sync.sv
module mdm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int               WIDTH  = 4,
  parameter int               STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], d[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {STAGES{RST_VAL[i]}};
      else        stg_q <= stg_d;
    end

    assign q[i] = stg_q[STAGES-1];
  end
endmodule

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output mdm_ctl_t         ctl
);
  mdm_ctl_t ctl_q;
  mdm_ctl_t ctl_d;

  always_comb begin
    ctl_d = mdm_ctl_t'(wdata[CTL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= CTL_RST;
    else if (wr) ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/mdm_status_core.sv
module mdm_status_core
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mdm_lines_t        line_s,
  input  logic              loop,
  input  logic              rd,
  output logic [NLINES-1:0] stat,
  output logic [NLINES-1:0] delta,
  output logic              any
);
  mdm_lines_t        stat_q;
  mdm_lines_t        stat_d;
  logic [NLINES-1:0] delta_q;
  logic [NLINES-1:0] delta_d;
  logic [NLINES-1:0] evt;
  mdm_lines_t        chg;
  logic              upd_en;
  logic              clr;

  always_comb begin
    chg      = line_s ^ stat_q;
    evt[3]   = chg.dcd;
    evt[2]   = stat_q.ri & ~line_s.ri;   // trailing edge only
    evt[1]   = chg.dsr;
    evt[0]   = chg.cts;
    upd_en   = ~loop;
    clr      = rd & ~loop;
    // a new event beats a clearing read
    delta_d  = (delta_q & ~{NLINES{clr}}) | evt;
    stat_d   = line_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= LINES_RST;
      delta_q <= '0;
    end else if (upd_en) begin
      stat_q  <= stat_d;
      delta_q <= delta_d;
    end
  end

  assign stat  = stat_q;
  assign delta = delta_q;
  assign any   = |delta_q;
endmodule

// File: rtl/mdm_rd_mux.sv
module mdm_rd_mux
  import mdm_pkg::*;
(
  input  mdm_ctl_t          ctl,
  input  logic [NLINES-1:0] stat,
  input  logic [NLINES-1:0] delta,
  output logic [REG_W-1:0]  rdata
);
  always_comb begin
    if (ctl.loop) rdata = {loop_map(ctl), {NLINES{1'b0}}};
    else          rdata = {stat, delta};
  end
endmodule

// File: rtl/modem_status_ctl.sv
module modem_status_ctl
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [4:0] ctl_q,
  input  logic       sts_rd,
  output logic [7:0] sts_rdata,
  input  logic       pin_cts,
  input  logic       pin_dsr,
  input  logic       pin_dcd,
  input  logic       pin_ri,
  output logic       delta_any
);
  logic              rst_core_n;
  mdm_lines_t        pins_raw;
  logic [NLINES-1:0] sync_vec;
  mdm_lines_t        line_sync;
  mdm_ctl_t          ctl;
  logic [NLINES-1:0] stat_q;
  logic [NLINES-1:0] delta_q;

  mdm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_out_n(rst_core_n)
  );

  always_comb begin
    pins_raw.dcd = pin_dcd;
    pins_raw.ri  = pin_ri;
    pins_raw.dsr = pin_dsr;
    pins_raw.cts = pin_cts;
  end

  mdm_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(LINES_RST)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d(pins_raw), .q(sync_vec)
  );
  assign line_sync = mdm_lines_t'(sync_vec);

  mdm_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_core_n), .wr(ctl_wr), .wdata(ctl_wdata), .ctl(ctl)
  );

  mdm_status_core u_core (
    .clk(clk), .rst_n(rst_core_n), .line_s(line_sync), .loop(ctl.loop),
    .rd(sts_rd), .stat(stat_q), .delta(delta_q), .any(delta_any)
  );

  mdm_rd_mux u_mux (
    .ctl(ctl), .stat(stat_q), .delta(delta_q), .rdata(sts_rdata)
  );

  assign ctl_q = ctl;
endmodule

// File: rtl/mdm_chk.sv
module mdm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] ctl_q,
  input logic [3:0] line_s,
  input logic [3:0] stat_q,
  input logic [3:0] delta_q,
  input logic       rd,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata
);
  logic loop;
  logic [3:0] chg;
  assign loop = ctl_q[4];
  assign chg  = (line_s ^ stat_q) & 4'b1011;

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_q == $past(ctl_wdata[4:0])); // R2

  AST_STAT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !loop |=> stat_q == $past(line_s)); // R3

  AST_DELTA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop && chg != 4'b0) |=> (delta_q & $past(chg)) == $past(chg)); // R7

  AST_TERI_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop && stat_q[2] && !line_s[2]) |=> delta_q[2]); // R5

  AST_TERI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop && !stat_q[2] && line_s[2] && !delta_q[2]) |=> !delta_q[2]); // R5

  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !loop && line_s == stat_q) |=> delta_q == 4'b0); // R6

  AST_LOOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    loop |=> ($stable(delta_q) && $stable(stat_q))); // R9
endmodule

bind modem_status_ctl mdm_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .ctl_q(ctl_q), .line_s(sync_vec),
  .stat_q(stat_q), .delta_q(delta_q), .rd(sts_rd), .ctl_wr(ctl_wr),
  .ctl_wdata(ctl_wdata)
);

// File: tb/tb_modem_status_ctl.sv
module tb_modem_status_ctl;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [7:0] ctl_wdata;
  logic [4:0] ctl_q;
  logic       sts_rd;
  logic [7:0] sts_rdata;
  logic       pin_cts, pin_dsr, pin_dcd, pin_ri;
  logic       delta_any;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  modem_status_ctl dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
    .pin_cts(pin_cts), .pin_dsr(pin_dsr), .pin_dcd(pin_dcd), .pin_ri(pin_ri),
    .delta_any(delta_any)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: got 0x%02h expected 0x%02h", req, what, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; sts_rd = 1'b0;
    pin_dcd = 1'b1; pin_ri = 1'b0; pin_dsr = 1'b1; pin_cts = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(5);
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  // read strobe is high for exactly one cycle starting at a falling edge
  task automatic read_sts(output logic [7:0] v);
    @(negedge clk); sts_rd = 1'b1; #1 v = sts_rdata;
    @(negedge clk); sts_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    apply_reset();
    check("R1", "control after reset", {3'b0, ctl_q}, 8'h08);
    check("R1", "delta_any after reset", {7'b0, delta_any}, 8'h00);
    read_sts(v);
    check("R1", "status after reset", v, 8'hB0);
  endtask

  task automatic t_ctl_write();
    write_ctl(8'hE3);
    check("R2", "upper bits dropped", {3'b0, ctl_q}, 8'h03);
    write_ctl(8'h0F);
    check("R2", "control write", {3'b0, ctl_q}, 8'h0F);
    write_ctl(8'h08);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    apply_reset();
    @(negedge clk); pin_cts = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R3", "no flag before third edge", {7'b0, delta_any}, 8'h00);
    @(negedge clk);
    check("R10", "flag at third edge", {7'b0, delta_any}, 8'h01);
    read_sts(v);
    check("R4", "cts fall flag", v, 8'hA1);
    read_sts(v);
    check("R6", "flags cleared by read", v, 8'hA0);
    check("R10", "delta_any after clear", {7'b0, delta_any}, 8'h00);
    @(negedge clk); pin_dcd = 1'b0; pin_dsr = 1'b0; pin_cts = 1'b1;
    idle(5);
    read_sts(v);
    check("R4", "three lines changed", v, 8'h1B);
    read_sts(v);
    check("R6", "second read clean", v, 8'h10);
    @(negedge clk); pin_dcd = 1'b1;
    idle(5);
    read_sts(v);
    check("R4", "dcd rise flag", v, 8'h98);
  endtask

  task automatic t_ring();
    logic [7:0] v;
    apply_reset();
    @(negedge clk); pin_ri = 1'b1;
    idle(5);
    check("R5", "ring rise no flag", {7'b0, delta_any}, 8'h00);
    read_sts(v);
    check("R5", "ring rise status", v, 8'hF0);
    @(negedge clk); pin_ri = 1'b0;
    idle(5);
    read_sts(v);
    check("R5", "ring fall flag", v, 8'hB4);
    read_sts(v);
    check("R6", "ring flag cleared", v, 8'hB0);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    apply_reset();
    @(negedge clk); pin_cts = 1'b0;
    idle(5);
    // event for dsr is computed in the cycle after the 2nd rising edge
    @(negedge clk); pin_dsr = 1'b0;
    @(negedge clk);
    @(negedge clk); sts_rd = 1'b1; #1 v = sts_rdata;
    @(negedge clk); sts_rd = 1'b0;
    check("R7", "read during event", v, 8'hA1);
    read_sts(v);
    check("R7", "event survived read", v, 8'h82);
    read_sts(v);
    check("R6", "all cleared", v, 8'h80);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    apply_reset();
    @(negedge clk); pin_cts = 1'b0;
    idle(5);
    write_ctl(8'h1A);
    read_sts(v);
    check("R8", "loop out2+rts", v, 8'h90);
    read_sts(v);
    check("R9", "loop read repeat", v, 8'h90);
    check("R9", "flag kept in loop", {7'b0, delta_any}, 8'h01);
    @(negedge clk); pin_dcd = 1'b0;
    idle(5);
    write_ctl(8'h15);
    read_sts(v);
    check("R8", "loop out1+dtr", v, 8'h60);
    write_ctl(8'h00);
    idle(2);
    read_sts(v);
    check("R9", "after loop exit", v, 8'h29);
    read_sts(v);
    check("R6", "cleared after exit", v, 8'h20);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired (all requirements)");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ctl_write();
    t_edges();
    t_ring();
    t_collide();
    t_loop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule